// File: doc/BRIEF.md
# Four-Channel PWM Configuration Register Bank

This block is the software-visible configuration store of a multi-channel pulse-width modulator. A bus master reaches it through a simple valid/ready register port carrying aligned 32-bit words; the block answers every accepted request one cycle later with read data and an error flag. The stored values drive the clock prescale unit (prescaler and clock-select words), a shared channel-control word, and each channel generator's period and compare values.

Period and compare writes clamp to the largest value a 16-bit counter can hold, instead of dropping the upper bits. When a write really changes a channel's period or compare value, that channel's update strobe rises for one cycle, in the same cycle the new value first appears on the channel outputs. The generator can then reload on that strobe.

Capture, interrupt-enable, interrupt-status and watchdog words are placeholders here, so they always read as zero. Writing to a capture word, an unmapped offset or a misaligned address pulses the error flag and changes nothing.

Top module: `pwm_regbank`

## Requirements
- R1: While rst_ni is low, and after it is released, every stored word reads zero. All configuration outputs, update strobes and response outputs are zero.
- R2: req_ready_o is always high. Every request accepted at a clock edge gets rsp_valid_o high for exactly the following cycle. A cycle without a request gives no response.
- R3: The words at offset 0x00 (prescaler), 0x04 (clock select) and 0x08 (channel control) store all 32 written bits. They read back unchanged and drive prescale_o, clk_sel_o and ch_ctrl_o from the cycle after the write. Without a write, these outputs hold their value.
- R4: Channel n has its period word at 0x0C+12n and its compare word at 0x10+12n. A read returns the stored 16-bit value, zero-extended. Channel n's value sits in bits [16n+15:16n] of period_o and compare_o.
- R5: A period or compare write with a value above 65535 stores 65535. Values up to 65535, including 65535 itself, are stored exactly.
- R6: A write that changes a channel's period or compare value raises upd_o[n] for one cycle, together with the new value on the outputs. A write of the value already stored gives no strobe.
- R7: Channel n's capture word at 0x14+12n always reads zero without error. A write to it is ignored and pulses rsp_err_o.
- R8: Interrupt enable (0x3C), interrupt status (0x40) and the per-channel watchdog words (0x44+4n) read zero. Writes to them are accepted without error and have no effect.
- R9: An access to an unmapped offset (0x54 and above) or with req_addr_i[1:0] not 00 pulses rsp_err_o, returns zero read data and leaves all stored state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready (always high) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 12 | Byte offset |
| req_wdata_i | input | 32 | Write data, little-endian word |
| rsp_valid_o | output | 1 | Response valid, one cycle after request |
| rsp_rdata_o | output | 32 | Read data (zero for writes and errors) |
| rsp_err_o | output | 1 | Error flag for the response |
| prescale_o | output | 32 | Prescaler word to clock prescale unit |
| clk_sel_o | output | 32 | Clock-select word to clock prescale unit |
| ch_ctrl_o | output | 32 | Channel control word |
| period_o | output | 64 | Per-channel period, 16 bits each |
| compare_o | output | 64 | Per-channel compare, 16 bits each |
| upd_o | output | 4 | Per-channel update strobe |

## Verification
A request driven before edge k has its response and its effect on the configuration outputs due after edge k. Both the response and the new period, compare and strobe values are valid during the cycle after that edge, and all of them drop or hold after edge k+1. The driver applies each request on a falling edge. It samples outputs only on the next falling edge, and it leaves one idle cycle before the next request, so a strobe is seen exactly once and a missing drop shows up as a mismatch on the following read. The monitor pops one expected response per rsp_valid_o cycle on falling edges. An extra or missing response is therefore caught as well as a wrong value.

// File: rtl/pwm_regbank_pkg.sv
package pwm_regbank_pkg;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_PRESCALE,
    SEL_CLKSEL,
    SEL_CTRL,
    SEL_PERIOD,
    SEL_COMPARE,
    SEL_CAPTURE,
    SEL_IRQ_EN,
    SEL_IRQ_STAT,
    SEL_WDOG
  } reg_sel_e;

  localparam int unsigned OFS_PRESCALE = 0;
  localparam int unsigned OFS_CLKSEL   = 4;
  localparam int unsigned OFS_CTRL     = 8;
  localparam int unsigned OFS_CH_BASE  = 12;
  localparam int unsigned CH_STRIDE    = 12;
  localparam int unsigned WORD_BYTES   = 4;

endpackage

// File: rtl/pwm_addr_dec.sv
module pwm_addr_dec
  import pwm_regbank_pkg::*;
#(
  parameter int unsigned AW  = 12,
  parameter int unsigned NCH = 4,
  localparam int unsigned CIW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [AW-1:0]  addr_i,
  output reg_sel_e       sel_o,
  output logic [CIW-1:0] ch_o
);

  localparam int unsigned IE_OFS = OFS_CH_BASE + CH_STRIDE * NCH;
  localparam int unsigned IS_OFS = IE_OFS + WORD_BYTES;
  localparam int unsigned WD_OFS = IS_OFS + WORD_BYTES;

  logic [31:0] a32;
  assign a32 = 32'(addr_i);

  always_comb begin
    sel_o = SEL_NONE;
    ch_o  = '0;
    if (addr_i[1:0] == 2'b00) begin
      if (a32 == 32'(OFS_PRESCALE))    sel_o = SEL_PRESCALE;
      else if (a32 == 32'(OFS_CLKSEL)) sel_o = SEL_CLKSEL;
      else if (a32 == 32'(OFS_CTRL))   sel_o = SEL_CTRL;
      else if (a32 == 32'(IE_OFS))     sel_o = SEL_IRQ_EN;
      else if (a32 == 32'(IS_OFS))     sel_o = SEL_IRQ_STAT;
      for (int c = 0; c < NCH; c++) begin
        if (a32 == 32'(OFS_CH_BASE + CH_STRIDE * c)) begin
          sel_o = SEL_PERIOD;
          ch_o  = CIW'(c);
        end
        if (a32 == 32'(OFS_CH_BASE + CH_STRIDE * c + WORD_BYTES)) begin
          sel_o = SEL_COMPARE;
          ch_o  = CIW'(c);
        end
        if (a32 == 32'(OFS_CH_BASE + CH_STRIDE * c + 2 * WORD_BYTES)) begin
          sel_o = SEL_CAPTURE;
          ch_o  = CIW'(c);
        end
        if (a32 == 32'(WD_OFS + WORD_BYTES * c)) begin
          sel_o = SEL_WDOG;
          ch_o  = CIW'(c);
        end
      end
    end
  end

endmodule

// File: rtl/pwm_shared_regs.sv
module pwm_shared_regs #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_pre_i,
  input  logic          we_csel_i,
  input  logic          we_ctrl_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] prescale_o,
  output logic [DW-1:0] clk_sel_o,
  output logic [DW-1:0] ch_ctrl_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prescale_o <= '0;
      clk_sel_o  <= '0;
      ch_ctrl_o  <= '0;
    end else begin
      if (we_pre_i)  prescale_o <= wdata_i;
      if (we_csel_i) clk_sel_o  <= wdata_i;
      if (we_ctrl_i) ch_ctrl_o  <= wdata_i;
    end
  end

endmodule

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs #(
  parameter int unsigned DW    = 32,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_per_i,
  input  logic             we_cmp_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [CNT_W-1:0] period_o,
  output logic [CNT_W-1:0] compare_o,
  output logic             upd_o
);

  localparam logic [DW-1:0] MAX_V = DW'((64'd1 << CNT_W) - 64'd1);

  logic [CNT_W-1:0] wsat;
  logic             per_chg, cmp_chg;

  // clamp instead of truncating the upper bits
  assign wsat    = (wdata_i > MAX_V) ? MAX_V[CNT_W-1:0] : wdata_i[CNT_W-1:0];
  assign per_chg = we_per_i && (wsat != period_o);
  assign cmp_chg = we_cmp_i && (wsat != compare_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_o  <= '0;
      compare_o <= '0;
      upd_o     <= 1'b0;
    end else begin
      upd_o <= per_chg || cmp_chg;
      if (we_per_i) period_o  <= wsat;
      if (we_cmp_i) compare_o <= wsat;
    end
  end

endmodule

// File: rtl/pwm_regbank.sv
module pwm_regbank
  import pwm_regbank_pkg::*;
#(
  parameter int unsigned AW    = 12,
  parameter int unsigned DW    = 32,
  parameter int unsigned NCH   = 4,
  parameter int unsigned CNT_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic               req_write_i,
  input  logic [AW-1:0]      req_addr_i,
  input  logic [DW-1:0]      req_wdata_i,
  output logic               rsp_valid_o,
  output logic [DW-1:0]      rsp_rdata_o,
  output logic               rsp_err_o,
  output logic [DW-1:0]      prescale_o,
  output logic [DW-1:0]      clk_sel_o,
  output logic [DW-1:0]      ch_ctrl_o,
  output logic [NCH*CNT_W-1:0] period_o,
  output logic [NCH*CNT_W-1:0] compare_o,
  output logic [NCH-1:0]     upd_o
);

  localparam int unsigned CIW = (NCH > 1) ? $clog2(NCH) : 1;

  reg_sel_e         sel;
  logic [CIW-1:0]   ch;
  logic             err, wr_ok;
  logic [DW-1:0]    rd;
  logic [CNT_W-1:0] per_a [NCH];
  logic [CNT_W-1:0] cmp_a [NCH];

  assign req_ready_o = 1'b1;

  pwm_addr_dec #(.AW(AW), .NCH(NCH)) i_dec (
    .addr_i (req_addr_i),
    .sel_o  (sel),
    .ch_o   (ch)
  );

  assign err   = req_valid_i && ((sel == SEL_NONE) || (req_write_i && sel == SEL_CAPTURE));
  assign wr_ok = req_valid_i && req_write_i && !err;

  pwm_shared_regs #(.DW(DW)) i_shared (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_pre_i   (wr_ok && sel == SEL_PRESCALE),
    .we_csel_i  (wr_ok && sel == SEL_CLKSEL),
    .we_ctrl_i  (wr_ok && sel == SEL_CTRL),
    .wdata_i    (req_wdata_i),
    .prescale_o (prescale_o),
    .clk_sel_o  (clk_sel_o),
    .ch_ctrl_o  (ch_ctrl_o)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;
    assign hit = wr_ok && (ch == CIW'(c));

    pwm_chan_regs #(.DW(DW), .CNT_W(CNT_W)) i_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .we_per_i  (hit && sel == SEL_PERIOD),
      .we_cmp_i  (hit && sel == SEL_COMPARE),
      .wdata_i   (req_wdata_i),
      .period_o  (per_a[c]),
      .compare_o (cmp_a[c]),
      .upd_o     (upd_o[c])
    );

    assign period_o[c*CNT_W +: CNT_W]  = per_a[c];
    assign compare_o[c*CNT_W +: CNT_W] = cmp_a[c];
  end

  // capture, irq and watchdog words are placeholders and read zero
  always_comb begin
    case (sel)
      SEL_PRESCALE: rd = prescale_o;
      SEL_CLKSEL:   rd = clk_sel_o;
      SEL_CTRL:     rd = ch_ctrl_o;
      SEL_PERIOD:   rd = DW'(per_a[ch]);
      SEL_COMPARE:  rd = DW'(cmp_a[ch]);
      default:      rd = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
      rsp_err_o   <= 1'b0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_rdata_o <= (req_valid_i && !req_write_i && !err) ? rd : '0;
      rsp_err_o   <= err;
    end
  end

endmodule

// File: rtl/pwm_regbank_chk.sv
module pwm_regbank_chk #(
  parameter int unsigned DW    = 32,
  parameter int unsigned NCH   = 4,
  parameter int unsigned CNT_W = 16
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_valid_i,
  input logic                 req_write_i,
  input logic [1:0]           addr_lo_i,
  input logic                 rsp_valid_o,
  input logic [DW-1:0]        rsp_rdata_o,
  input logic                 rsp_err_o,
  input logic [DW-1:0]        prescale_o,
  input logic [DW-1:0]        clk_sel_o,
  input logic [DW-1:0]        ch_ctrl_o,
  input logic [NCH*CNT_W-1:0] period_o,
  input logic [NCH*CNT_W-1:0] compare_o,
  input logic [NCH-1:0]       upd_o
);

  AST_RSP_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o); // R2

  AST_NO_RSP_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o); // R2

  AST_ERR_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> (rsp_valid_o && rsp_rdata_o == '0)); // R9

  AST_MISALIGNED_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && addr_lo_i != 2'b00) |=>
      ($stable(prescale_o) && $stable(clk_sel_o) && $stable(ch_ctrl_o) &&
       $stable(period_o) && $stable(compare_o))); // R9

  AST_MISALIGNED_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && addr_lo_i != 2'b00) |=> rsp_err_o); // R9

  AST_CFG_HOLDS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && req_write_i) |=>
      ($stable(prescale_o) && $stable(clk_sel_o) && $stable(ch_ctrl_o) &&
       $stable(period_o) && $stable(compare_o))); // R3

  AST_NO_UPD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && req_write_i) |=> (upd_o == '0)); // R6

  for (genvar c = 0; c < NCH; c++) begin : g_upd
    AST_UPD_MEANS_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      upd_o[c] |-> ((period_o[c*CNT_W +: CNT_W] != $past(period_o[c*CNT_W +: CNT_W])) ||
                    (compare_o[c*CNT_W +: CNT_W] != $past(compare_o[c*CNT_W +: CNT_W])))); // R6
  end

endmodule

bind pwm_regbank pwm_regbank_chk #(.DW(DW), .NCH(NCH), .CNT_W(CNT_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_write_i (req_write_i),
  .addr_lo_i   (req_addr_i[1:0]),
  .rsp_valid_o (rsp_valid_o),
  .rsp_rdata_o (rsp_rdata_o),
  .rsp_err_o   (rsp_err_o),
  .prescale_o  (prescale_o),
  .clk_sel_o   (clk_sel_o),
  .ch_ctrl_o   (ch_ctrl_o),
  .period_o    (period_o),
  .compare_o   (compare_o),
  .upd_o       (upd_o)
);

// File: tb/test_pwm_regbank.sv
`timescale 1ns/1ps
module test_pwm_regbank;

  localparam int NCH = 4;
  localparam int CW  = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            valid = 1'b0, write = 1'b0;
  logic [11:0]     addr = '0;
  logic [31:0]     wdata = '0;
  logic            ready, rsp_valid, rsp_err;
  logic [31:0]     rsp_rdata, pre, csel, ctrl;
  logic [NCH*CW-1:0] per, cmp;
  logic [NCH-1:0]  upd;

  always #2.5 clk = ~clk;

  pwm_regbank i_pwm_regbank (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(valid), .req_ready_o(ready), .req_write_i(write),
    .req_addr_i(addr), .req_wdata_i(wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .rsp_err_o(rsp_err),
    .prescale_o(pre), .clk_sel_o(csel), .ch_ctrl_o(ctrl),
    .period_o(per), .compare_o(cmp), .upd_o(upd)
  );

  typedef struct {
    logic [31:0] d;
    logic        e;
    string       tag;
  } exp_t;

  exp_t sbq[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  logic [31:0] m_pre = '0, m_csel = '0, m_ctrl = '0;
  logic [15:0] m_per [NCH];
  logic [15:0] m_cmp [NCH];
  logic [NCH-1:0] m_upd;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: one expected item per response cycle
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sbq.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R2 unexpected response act=%h exp=none", rsp_rdata);
      end else begin
        exp_t x;
        x = sbq.pop_front();
        chk({x.tag, " rdata"}, rsp_rdata, x.d);
        chk({x.tag, " err"}, 32'(rsp_err), 32'(x.e));
      end
    end
  end

  task automatic access(bit w, logic [11:0] a, logic [31:0] d,
                        logic [31:0] erd, bit eerr, string tag);
    exp_t x;
    @(negedge clk);
    valid = 1'b1; write = w; addr = a; wdata = d;
    x.d = erd; x.e = eerr; x.tag = tag;
    sbq.push_back(x);
    @(negedge clk);
    valid = 1'b0; write = 1'b0;
  endtask

  function automatic logic [15:0] sat(logic [31:0] d);
    return (d > 32'hFFFF) ? 16'hFFFF : d[15:0];
  endfunction

  task automatic check_outputs(string tag);
    chk({tag, " prescale"}, pre, m_pre);
    chk({tag, " clk_sel"}, csel, m_csel);
    chk({tag, " ctrl"}, ctrl, m_ctrl);
    for (int n = 0; n < NCH; n++) begin
      chk({tag, " period"}, 32'(per[n*CW +: CW]), 32'(m_per[n]));
      chk({tag, " compare"}, 32'(cmp[n*CW +: CW]), 32'(m_cmp[n]));
    end
    chk({tag, " upd"}, 32'(upd), 32'(m_upd));
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, bit eerr, string tag);
    m_upd = '0;
    if (!eerr) begin
      if (a == 12'h000) m_pre = d;
      if (a == 12'h004) m_csel = d;
      if (a == 12'h008) m_ctrl = d;
      for (int n = 0; n < NCH; n++) begin
        if (a == 12'(12 + 12*n)) begin
          if (sat(d) != m_per[n]) m_upd[n] = 1'b1;
          m_per[n] = sat(d);
        end
        if (a == 12'(16 + 12*n)) begin
          if (sat(d) != m_cmp[n]) m_upd[n] = 1'b1;
          m_cmp[n] = sat(d);
        end
      end
    end
    access(1'b1, a, d, 32'h0, eerr, tag);
    check_outputs(tag);
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] exp, bit eerr, string tag);
    m_upd = '0;
    access(1'b0, a, 32'hDEAD_BEEF, exp, eerr, tag);
    check_outputs(tag);
  endtask

  initial begin
    for (int n = 0; n < NCH; n++) begin
      m_per[n] = '0;
      m_cmp[n] = '0;
    end
    m_upd = '0;
    repeat (3) @(negedge clk);
    // R1: state during reset
    check_outputs("R1 in reset");
    chk("R1 rsp_valid in reset", 32'(rsp_valid), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check_outputs("R1 after reset");
    chk("R2 ready", 32'(ready), 32'h1);
    rd(12'h000, 32'h0, 1'b0, "R1 prescale read");
    rd(12'h00C, 32'h0, 1'b0, "R1 period0 read");

    wr(12'h000, 32'hA5A5_0102, 1'b0, "R3 prescale write");
    wr(12'h004, 32'h0000_3210, 1'b0, "R3 clksel write");
    wr(12'h008, 32'h0001_1109, 1'b0, "R3 ctrl write");
    rd(12'h000, 32'hA5A5_0102, 1'b0, "R3 prescale read");
    rd(12'h004, 32'h0000_3210, 1'b0, "R3 clksel read");
    rd(12'h008, 32'h0001_1109, 1'b0, "R3 ctrl read");

    wr(12'h00C, 32'd1000, 1'b0, "R4 R6 period0 write");
    rd(12'h00C, 32'd1000, 1'b0, "R4 period0 read");
    wr(12'h034, 32'd500, 1'b0, "R4 R6 compare3 write");
    rd(12'h034, 32'd500, 1'b0, "R4 compare3 read");

    wr(12'h018, 32'h0001_0000, 1'b0, "R5 period1 saturate");
    rd(12'h018, 32'h0000_FFFF, 1'b0, "R5 period1 read");
    wr(12'h028, 32'hFFFF_FFFF, 1'b0, "R5 compare2 saturate");
    rd(12'h028, 32'h0000_FFFF, 1'b0, "R5 compare2 read");
    wr(12'h024, 32'h0000_FFFF, 1'b0, "R5 period2 exact max");
    rd(12'h024, 32'h0000_FFFF, 1'b0, "R5 period2 read");
    wr(12'h018, 32'h0002_0000, 1'b0, "R6 period1 same saturated no strobe");
    wr(12'h00C, 32'd1000, 1'b0, "R6 period0 same value no strobe");
    wr(12'h00C, 32'd999, 1'b0, "R6 period0 new value strobe");

    wr(12'h020, 32'h0000_1234, 1'b1, "R7 capture1 write ignored");
    rd(12'h020, 32'h0, 1'b0, "R7 capture1 read");
    rd(12'h038, 32'h0, 1'b0, "R7 capture3 read");

    wr(12'h03C, 32'hFFFF_FFFF, 1'b0, "R8 irq enable write");
    rd(12'h03C, 32'h0, 1'b0, "R8 irq enable read");
    wr(12'h040, 32'h0000_000F, 1'b0, "R8 irq status write");
    rd(12'h040, 32'h0, 1'b0, "R8 irq status read");
    wr(12'h044, 32'h1111_1111, 1'b0, "R8 watchdog0 write");
    wr(12'h050, 32'h2222_2222, 1'b0, "R8 watchdog3 write");
    rd(12'h050, 32'h0, 1'b0, "R8 watchdog3 read");

    wr(12'h054, 32'h0000_0077, 1'b1, "R9 unmapped write");
    rd(12'h054, 32'h0, 1'b1, "R9 unmapped read");
    rd(12'hFFC, 32'h0, 1'b1, "R9 top unmapped read");
    wr(12'h00E, 32'h0000_0055, 1'b1, "R9 misaligned period write");
    wr(12'h001, 32'h0000_0055, 1'b1, "R9 misaligned prescale write");
    rd(12'h00D, 32'h0, 1'b1, "R9 misaligned read");
    rd(12'h00C, 32'd999, 1'b0, "R9 period0 intact");

    repeat (3) @(negedge clk);
    chk("R2 all responses seen", 32'(sbq.size()), 32'h0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule